// File: doc/BRIEF.md
# Debug-State Bus Isolation Wrapper

This block sits between a processor core and the memory system around it. While the core is halted in debug state, the system keeps running, so the core's bus activity must not be taken as real memory traffic. Instructions are fed in one at a time during debug, and each one can move the address bus. The wrapper registers a debug-state request. While that state is active it drives the memory-request and sequential-cycle lines toward the system with the code for an internal (idle) cycle. It also holds the abort and interrupt lines toward the core in their inactive levels. Every other core output, such as the address and the write strobe, passes straight through and may toggle freely.

The block also watches the system for conditions that would corrupt the debug session. At debug entry it captures the endianness select and the active-low core reset request, and flags any later change in either. Whenever the debug clock ticks, it also checks that all byte-latch enables are high. Each kind of violation has a sticky cause bit. The bits gather while debug lasts and all of them clear when debug is exited. A debugger or a system monitor reads them to decide whether the halted core's state can still be trusted.

Top module: `dbg_bus_iso`

## Requirements
- R1: While reset is applied and after it is released, `debug_state_o` is 0, `viol_o` is 0 and `viol_kind_o` is 0 until a debug request is seen.
- R2: `debug_state_o` equals the value `dbg_active_i` had at the previous rising clock edge.
- R3: While `debug_state_o` is 1, `sys_mreq_n_o` is 1 and `sys_seq_o` is 0 (the internal-cycle code), whatever the core drives.
- R4: While `debug_state_o` is 0, `sys_mreq_n_o` and `sys_seq_o` equal `core_mreq_n_i` and `core_seq_i` in the same cycle.
- R5: While `debug_state_o` is 1, `core_abort_o` is 0 and every bit of `core_irq_n_o` is 1. While it is 0, they equal `sys_abort_i` and `sys_irq_n_i`.
- R6: `sys_addr_o` and `sys_wr_o` always equal `core_addr_i` and `core_wr_i` in the same cycle, in and out of debug.
- R7: The value of `endian_i` is captured at the edge where `debug_state_o` rises. If a later debug cycle, with `dbg_active_i` still 1, sees a different value, `viol_kind_o[0]` is 1 after the next edge.
- R8: The same capture and check applies to `core_rst_req_n_i`, and the result goes to `viol_kind_o[1]`.
- R9: In a debug cycle with `dclk_tick_i` = 1 and `dbg_active_i` = 1, any bit of `ble_i` at 0 sets `viol_kind_o[2]` after the next edge. With `dclk_tick_i` = 0, a low `ble_i` has no effect.
- R10: Cause bits are sticky and accumulate while `dbg_active_i` stays 1. `viol_o` is 1 exactly when any cause bit is 1.
- R11: At the edge that samples `dbg_active_i` = 0, all cause bits clear. Outside debug, no input change sets any cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dbg_active_i | input | 1 | Debug-state request from the debug controller |
| core_mreq_n_i | input | 1 | Active-low memory request from the core |
| core_seq_i | input | 1 | Sequential-cycle indication from the core |
| core_addr_i | input | AW (32) | Address from the core |
| core_wr_i | input | 1 | Write strobe from the core |
| sys_mreq_n_o | output | 1 | Memory request toward the system |
| sys_seq_o | output | 1 | Sequential-cycle indication toward the system |
| sys_addr_o | output | AW (32) | Address toward the system |
| sys_wr_o | output | 1 | Write strobe toward the system |
| sys_abort_i | input | 1 | Abort from the memory system |
| sys_irq_n_i | input | NIRQ (2) | Active-low interrupt lines from the system |
| core_abort_o | output | 1 | Abort toward the core |
| core_irq_n_o | output | NIRQ (2) | Active-low interrupt lines toward the core |
| ble_i | input | NBL (4) | Byte-latch enables |
| dclk_tick_i | input | 1 | High in a cycle where the debug clock ticks |
| endian_i | input | 1 | Endianness select |
| core_rst_req_n_i | input | 1 | Active-low reset request toward the core (monitored) |
| debug_state_o | output | 1 | Registered debug state |
| viol_o | output | 1 | Any stability violation recorded |
| viol_kind_o | output | 3 | Cause bits: [0] endianness, [1] reset, [2] byte-latch enable |

## Verification
The debug state is due one edge after the request is sampled. Forcing, masking and pass-through are combinational on that state and on the current inputs, so they are due in the same cycle. A violation seen in a debug cycle shows in the cause bits one edge later. The clear takes effect at the same edge that drops the debug state. The bench drives inputs at the falling edge and keeps its model in step at each rising edge, using the inputs held across that edge. It then compares every output shortly after the edge, so each result is checked in exactly the cycle it is due.

// File: rtl/dbg_bus_iso_pkg.sv
package dbg_bus_iso_pkg;

  // Cause record; packed so that endianness lands in bit 0.
  typedef struct packed {
    logic ble;
    logic rst;
    logic endian;
  } viol_t;

  localparam int unsigned VIOL_W = $bits(viol_t);

endpackage

// File: rtl/dbi_rst_sync.sv
module dbi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dbi_state.sv
module dbi_state (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_req,
  input  logic endian,
  input  logic rst_req_n,
  output logic dbg_q,
  output logic ref_endian,
  output logic ref_rst_n
);

  logic dbg_d;
  logic ref_endian_d;
  logic ref_rst_n_d;
  logic entry;

  always_comb begin
    entry        = dbg_req & ~dbg_q;
    dbg_d        = dbg_req;
    ref_endian_d = ref_endian;
    ref_rst_n_d  = ref_rst_n;
    if (entry) begin
      ref_endian_d = endian;
      ref_rst_n_d  = rst_req_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q      <= 1'b0;
      ref_endian <= 1'b0;
      ref_rst_n  <= 1'b1;
    end else begin
      dbg_q <= dbg_d;
      if (entry) begin
        ref_endian <= ref_endian_d;
        ref_rst_n  <= ref_rst_n_d;
      end
    end
  end

endmodule

// File: rtl/dbi_force.sv
module dbi_force #(
  parameter int unsigned AW          = 32,
  parameter int unsigned NIRQ        = 2,
  parameter bit          IDLE_MREQ_N = 1'b1,
  parameter bit          IDLE_SEQ    = 1'b0
) (
  input  logic            dbg_q,
  input  logic            core_mreq_n,
  input  logic            core_seq,
  input  logic [AW-1:0]   core_addr,
  input  logic            core_wr,
  output logic            sys_mreq_n,
  output logic            sys_seq,
  output logic [AW-1:0]   sys_addr,
  output logic            sys_wr,
  input  logic            sys_abort,
  input  logic [NIRQ-1:0] sys_irq_n,
  output logic            core_abort,
  output logic [NIRQ-1:0] core_irq_n
);

  always_comb begin
    sys_mreq_n = dbg_q ? IDLE_MREQ_N : core_mreq_n;
    sys_seq    = dbg_q ? IDLE_SEQ    : core_seq;
    core_abort = sys_abort & ~dbg_q;
  end

  assign sys_addr = core_addr;
  assign sys_wr   = core_wr;

  for (genvar g = 0; g < NIRQ; g++) begin : g_irq_mask
    assign core_irq_n[g] = sys_irq_n[g] | dbg_q;
  end

endmodule

// File: rtl/dbi_stab_mon.sv
module dbi_stab_mon
  import dbg_bus_iso_pkg::*;
#(
  parameter int unsigned NBL = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dbg_q,
  input  logic           dbg_req,
  input  logic           endian,
  input  logic           rst_req_n,
  input  logic           ref_endian,
  input  logic           ref_rst_n,
  input  logic [NBL-1:0] ble,
  input  logic           dclk_tick,
  output viol_t          kind_q
);

  viol_t hit;
  viol_t kind_d;

  always_comb begin
    hit.endian = dbg_q & (endian    != ref_endian);
    hit.rst    = dbg_q & (rst_req_n != ref_rst_n);
    hit.ble    = dbg_q & dclk_tick & ~(&ble);
    kind_d     = dbg_req ? (kind_q | hit) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kind_q <= '0;
    else        kind_q <= kind_d;
  end

endmodule

// File: rtl/dbg_bus_iso.sv
module dbg_bus_iso
  import dbg_bus_iso_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned NIRQ = 2,
  parameter int unsigned NBL  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbg_active_i,
  input  logic            core_mreq_n_i,
  input  logic            core_seq_i,
  input  logic [AW-1:0]   core_addr_i,
  input  logic            core_wr_i,
  output logic            sys_mreq_n_o,
  output logic            sys_seq_o,
  output logic [AW-1:0]   sys_addr_o,
  output logic            sys_wr_o,
  input  logic            sys_abort_i,
  input  logic [NIRQ-1:0] sys_irq_n_i,
  output logic            core_abort_o,
  output logic [NIRQ-1:0] core_irq_n_o,
  input  logic [NBL-1:0]  ble_i,
  input  logic            dclk_tick_i,
  input  logic            endian_i,
  input  logic            core_rst_req_n_i,
  output logic            debug_state_o,
  output logic            viol_o,
  output logic [VIOL_W-1:0] viol_kind_o
);

  logic  rst_sync_n;
  logic  dbg_q;
  logic  ref_endian;
  logic  ref_rst_n;
  viol_t kind_q;

  dbi_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dbi_state u_state (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .dbg_req    (dbg_active_i),
    .endian     (endian_i),
    .rst_req_n  (core_rst_req_n_i),
    .dbg_q      (dbg_q),
    .ref_endian (ref_endian),
    .ref_rst_n  (ref_rst_n)
  );

  dbi_force #(
    .AW          (AW),
    .NIRQ        (NIRQ),
    .IDLE_MREQ_N (1'b1),
    .IDLE_SEQ    (1'b0)
  ) u_force (
    .dbg_q       (dbg_q),
    .core_mreq_n (core_mreq_n_i),
    .core_seq    (core_seq_i),
    .core_addr   (core_addr_i),
    .core_wr     (core_wr_i),
    .sys_mreq_n  (sys_mreq_n_o),
    .sys_seq     (sys_seq_o),
    .sys_addr    (sys_addr_o),
    .sys_wr      (sys_wr_o),
    .sys_abort   (sys_abort_i),
    .sys_irq_n   (sys_irq_n_i),
    .core_abort  (core_abort_o),
    .core_irq_n  (core_irq_n_o)
  );

  dbi_stab_mon #(.NBL(NBL)) u_mon (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .dbg_q      (dbg_q),
    .dbg_req    (dbg_active_i),
    .endian     (endian_i),
    .rst_req_n  (core_rst_req_n_i),
    .ref_endian (ref_endian),
    .ref_rst_n  (ref_rst_n),
    .ble        (ble_i),
    .dclk_tick  (dclk_tick_i),
    .kind_q     (kind_q)
  );

  assign debug_state_o = dbg_q;
  assign viol_kind_o   = kind_q;
  assign viol_o        = |kind_q;

endmodule

// File: rtl/dbg_bus_iso_chk.sv
module dbg_bus_iso_chk #(
  parameter int unsigned AW   = 32,
  parameter int unsigned NIRQ = 2
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            dbg_active_i,
  input logic            debug_state_o,
  input logic            core_mreq_n_i,
  input logic            core_seq_i,
  input logic [AW-1:0]   core_addr_i,
  input logic            sys_mreq_n_o,
  input logic            sys_seq_o,
  input logic [AW-1:0]   sys_addr_o,
  input logic            core_abort_o,
  input logic [NIRQ-1:0] core_irq_n_o,
  input logic            viol_o
);

  AST_STATE_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dbg_active_i |=> debug_state_o); // R2
  AST_STATE_FALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dbg_active_i |=> !debug_state_o); // R2
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    debug_state_o |-> (sys_mreq_n_o && !sys_seq_o)); // R3
  AST_PASS_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !debug_state_o |-> (sys_mreq_n_o == core_mreq_n_i && sys_seq_o == core_seq_i)); // R4
  AST_MASKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    debug_state_o |-> (!core_abort_o && (&core_irq_n_o))); // R5
  AST_ADDR_FREE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sys_addr_o == core_addr_i); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (viol_o && dbg_active_i) |=> viol_o); // R10
  AST_CLEAR_OUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !debug_state_o |-> !viol_o); // R11

endmodule

bind dbg_bus_iso dbg_bus_iso_chk #(.AW(AW), .NIRQ(NIRQ)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .dbg_active_i  (dbg_active_i),
  .debug_state_o (debug_state_o),
  .core_mreq_n_i (core_mreq_n_i),
  .core_seq_i    (core_seq_i),
  .core_addr_i   (core_addr_i),
  .sys_mreq_n_o  (sys_mreq_n_o),
  .sys_seq_o     (sys_seq_o),
  .sys_addr_o    (sys_addr_o),
  .core_abort_o  (core_abort_o),
  .core_irq_n_o  (core_irq_n_o),
  .viol_o        (viol_o)
);

// File: tb/dbg_bus_iso_bench.sv
module dbg_bus_iso_bench;

  localparam int unsigned AW   = 32;
  localparam int unsigned NIRQ = 2;
  localparam int unsigned NBL  = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            dbg_active_i;
  logic            core_mreq_n_i, core_seq_i, core_wr_i;
  logic [AW-1:0]   core_addr_i;
  logic            sys_mreq_n_o, sys_seq_o, sys_wr_o;
  logic [AW-1:0]   sys_addr_o;
  logic            sys_abort_i;
  logic [NIRQ-1:0] sys_irq_n_i;
  logic            core_abort_o;
  logic [NIRQ-1:0] core_irq_n_o;
  logic [NBL-1:0]  ble_i;
  logic            dclk_tick_i, endian_i, core_rst_req_n_i;
  logic            debug_state_o, viol_o;
  logic [2:0]      viol_kind_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  // Bench model state
  bit       m_dbg;
  bit       m_ref_e;
  bit       m_ref_r;
  bit [2:0] m_kind;

  always #5 clk = ~clk;

  dbg_bus_iso #(.AW(AW), .NIRQ(NIRQ), .NBL(NBL)) u_dbg_bus_iso (
    .clk(clk), .rst_n(rst_n), .dbg_active_i(dbg_active_i),
    .core_mreq_n_i(core_mreq_n_i), .core_seq_i(core_seq_i),
    .core_addr_i(core_addr_i), .core_wr_i(core_wr_i),
    .sys_mreq_n_o(sys_mreq_n_o), .sys_seq_o(sys_seq_o),
    .sys_addr_o(sys_addr_o), .sys_wr_o(sys_wr_o),
    .sys_abort_i(sys_abort_i), .sys_irq_n_i(sys_irq_n_i),
    .core_abort_o(core_abort_o), .core_irq_n_o(core_irq_n_o),
    .ble_i(ble_i), .dclk_tick_i(dclk_tick_i), .endian_i(endian_i),
    .core_rst_req_n_i(core_rst_req_n_i), .debug_state_o(debug_state_o),
    .viol_o(viol_o), .viol_kind_o(viol_kind_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [2:0] next_kind(bit dbg, bit req, bit [2:0] kind,
                                         bit e, bit r, bit [NBL-1:0] b, bit tick);
    bit [2:0] hit;
    hit[0] = dbg && (e != m_ref_e);
    hit[1] = dbg && (r != m_ref_r);
    hit[2] = dbg && tick && (b != '1);
    return req ? (kind | hit) : 3'b000;
  endfunction

  // Advance one clock: inputs already set at the falling edge.
  task automatic cycle();
    @(posedge clk);
    m_kind = next_kind(m_dbg, dbg_active_i, m_kind, endian_i, core_rst_req_n_i, ble_i, dclk_tick_i);
    if (dbg_active_i && !m_dbg) begin
      m_ref_e = endian_i;
      m_ref_r = core_rst_req_n_i;
    end
    m_dbg = dbg_active_i;
    #2;
    chk("R2 debug state", debug_state_o, m_dbg);
    if (m_dbg) begin
      chk("R3 mreq idle", sys_mreq_n_o, 1'b1);
      chk("R3 seq idle", sys_seq_o, 1'b0);
    end else begin
      chk("R4 mreq pass", sys_mreq_n_o, core_mreq_n_i);
      chk("R4 seq pass", sys_seq_o, core_seq_i);
    end
    chk("R5 abort", core_abort_o, m_dbg ? 1'b0 : sys_abort_i);
    chk("R5 irq", core_irq_n_o, m_dbg ? {NIRQ{1'b1}} : sys_irq_n_i);
    chk("R6 addr", sys_addr_o, core_addr_i);
    chk("R6 wr", sys_wr_o, core_wr_i);
    chk("R10 cause bits", viol_kind_o, m_kind);
    chk("R10 viol", viol_o, |m_kind);
  endtask

  // Random core/system activity; violation inputs only if allowed.
  task automatic drive(input bit dbg, input bit allow_viol);
    @(negedge clk);
    dbg_active_i  = dbg;
    core_mreq_n_i = 1'($urandom);
    core_seq_i    = 1'($urandom);
    core_wr_i     = 1'($urandom);
    core_addr_i   = $urandom;
    sys_abort_i   = 1'($urandom);
    sys_irq_n_i   = NIRQ'($urandom);
    dclk_tick_i   = 1'($urandom);
    if (allow_viol) begin
      if ($urandom_range(15) == 0) endian_i = ~endian_i;
      if ($urandom_range(15) == 0) core_rst_req_n_i = ~core_rst_req_n_i;
      ble_i = ($urandom_range(7) == 0) ? NBL'($urandom) : '1;
    end else begin
      ble_i = '1;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    rst_n = 1'b0;
    dbg_active_i = 1'b1; core_mreq_n_i = 1'b0; core_seq_i = 1'b1;
    core_wr_i = 1'b1; core_addr_i = 32'hCAFE_0001; sys_abort_i = 1'b1;
    sys_irq_n_i = '0; ble_i = '0; dclk_tick_i = 1'b1;
    endian_i = 1'b0; core_rst_req_n_i = 1'b1;
    m_dbg = 0; m_ref_e = 0; m_ref_r = 1; m_kind = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset holds state low even with a debug request and bad inputs
    chk("R1 state in reset", debug_state_o, 1'b0);
    chk("R1 viol in reset", viol_o, 1'b0);
    chk("R1 kind in reset", viol_kind_o, 3'b000);
    chk("R4 pass in reset", sys_mreq_n_o, 1'b0);
    @(negedge clk);
    dbg_active_i = 1'b0; ble_i = '1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 state after reset", debug_state_o, 1'b0);
    chk("R1 viol after reset", viol_o, 1'b0);

    // R11: changes outside debug record nothing
    drive(1'b0, 1'b0); endian_i = ~endian_i; ble_i = '0; dclk_tick_i = 1'b1; cycle();
    drive(1'b0, 1'b0); core_rst_req_n_i = 1'b0; cycle();
    chk("R11 no viol outside", viol_kind_o, 3'b000);
    drive(1'b0, 1'b0); core_rst_req_n_i = 1'b1; cycle();

    // R2/R3: entry, forcing under random core activity
    drive(1'b1, 1'b0); cycle();
    chk("R2 entered", debug_state_o, 1'b1);
    for (int i = 0; i < 8; i++) begin drive(1'b1, 1'b0); cycle(); end

    // R9: low enable without tick is harmless
    drive(1'b1, 1'b0); ble_i = 4'b1011; dclk_tick_i = 1'b0; cycle();
    drive(1'b1, 1'b0); dclk_tick_i = 1'b0; cycle();
    chk("R9 no tick no viol", viol_kind_o, 3'b000);
    // R9: low enable on tick
    drive(1'b1, 1'b0); ble_i = 4'b0111; dclk_tick_i = 1'b1; cycle();
    drive(1'b1, 1'b0); cycle();
    chk("R9 ble viol", viol_kind_o, 3'b100);
    // R7: endianness change, then restore; R10 sticky accumulation
    drive(1'b1, 1'b0); endian_i = ~endian_i; cycle();
    drive(1'b1, 1'b0); endian_i = ~endian_i; cycle();
    chk("R7 endian viol", viol_kind_o, 3'b101);
    // R8: reset request pulse
    drive(1'b1, 1'b0); core_rst_req_n_i = 1'b0; cycle();
    drive(1'b1, 1'b0); core_rst_req_n_i = 1'b1; cycle();
    chk("R8 reset viol", viol_kind_o, 3'b111);
    for (int i = 0; i < 4; i++) begin drive(1'b1, 1'b0); cycle(); end
    chk("R10 sticky", viol_o, 1'b1);
    // R11: exit clears at the same edge state drops
    drive(1'b0, 1'b0); cycle();
    chk("R11 cleared", viol_kind_o, 3'b000);
    chk("R11 state off", debug_state_o, 1'b0);

    // R7: entry captures a non-default endianness; no false flag
    drive(1'b0, 1'b0); endian_i = 1'b1; cycle();
    drive(1'b1, 1'b0); cycle();
    for (int i = 0; i < 3; i++) begin drive(1'b1, 1'b0); cycle(); end
    chk("R7 captured value", viol_kind_o, 3'b000);
    // violation in the last debug cycle is dropped by the exit
    drive(1'b0, 1'b0); endian_i = 1'b0; cycle();
    chk("R11 exit wins", viol_kind_o, 3'b000);

    // Constrained random sessions
    for (int s = 0; s < 60; s++) begin
      int unsigned idle_len = $urandom_range(6, 1);
      int unsigned dbg_len  = $urandom_range(30, 1);
      for (int i = 0; i < idle_len; i++) begin drive(1'b0, 1'b1); cycle(); end
      for (int i = 0; i < dbg_len;  i++) begin drive(1'b1, 1'b1); cycle(); end
    end
    drive(1'b0, 1'b0); cycle();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule